// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Reads

This block is an I2C target that lets a host read a bank of 16-bit control registers. The bank lives outside the block. The block presents a register index on `rd_addr`, and the register file returns that register's contents on `rd_data`. The host sets the index with a short write: the device address with the write bit, followed by one register-number byte. It then issues a repeated START and reads. Each register goes out as two bytes, the upper byte first. After the lower byte, the index steps to the next register, so one burst can read any number of registers in a row.

A host can also skip the address phase. A read that opens directly with the device address and the read bit starts from the index left by the previous transfer. The index wraps from the last register back to register zero.

The bus pins are open-drain. The block samples SCL and SDA through a two-flop synchronizer and drives SDA low through `sda_oe`. It never holds SCL (no clock stretching). It supports only 7-bit addressing and does not answer the general-call address.

Top module: `i2c_regbank_target`

## Requirements
- R1: After a synchronous reset, `sda_oe` is 0, and `rd_addr` is 0 from the first clock after reset.
- R2: The target acknowledges a device address byte whose upper seven bits equal `DEV_ID`, for either value of the R/W bit (bit 0, 1 = read). On a mismatch it leaves SDA released for the rest of that transaction, and the register index is unchanged.
- R3: In a write, the target acknowledges the register-number byte and loads its low `REG_AW` bits into the index. It does not acknowledge any further byte of that write.
- R4: Each register is sent as two bytes, bits 15..8 first and then bits 7..0. Within a byte the most significant bit goes first.
- R5: The index increments by one when the ACK/NACK slot of a register's lower byte is sampled, and wraps from `2**REG_AW-1` to 0.
- R6: A read with no preceding address phase starts from the current index, which is the register after the last one fully read.
- R7: A host NACK on a data byte ends the read. The target keeps SDA released until the next START or STOP, and a register whose lower byte was not sent does not advance the index.
- R8: `sda_oe` changes only while SCL is low.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. A START or repeated START (SDA falling while SCL is high) restarts device address reception.
- R10: `rd_data` must be valid within 2 clocks after `rd_addr` changes. The target uses it only at SCL falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | output | REG_AW | Register index presented to the register file |
| rd_data | input | 16 | Contents of the register at `rd_addr` |

## Verification
The bench reads bursts that cross the top of the bank, so a pointer that saturates or overruns the wrap would return the wrong register after index 15. It uses an address byte with its upper bits set, which catches a pointer loaded from the wrong bits. It starts reads with no address phase after normal bursts, after a foreign device address, after a write with an extra data byte, and after a host NACK on an upper byte. These expose an index that moves on a mismatch, on an incomplete register, or on a rejected write byte. It also clocks eight more bits after a host NACK and expects all ones, which catches a target that keeps driving data after the host has stopped.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_DEC,
    ST_ACK_W,
    ST_REG,
    ST_REG_DEC,
    ST_ACK_A,
    ST_ACK_R,
    ST_TX,
    ST_RACK,
    ST_RACK_GO,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_now;

  assign scl_now = scl_ff[SYNC_STAGES-1];
  assign sda_s   = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_now;
      sda_q  <= sda_s;
    end
  end

  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [REG_AW-1:0] load_val,
  input  logic              inc,
  output logic [REG_AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h1A,
  parameter int REG_AW = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic [REG_AW-1:0] ptr_val,
  output logic              ptr_inc,
  output tgt_state_e        state
);
  localparam int BYTES = DATA_W / 8;
  localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [2:0]    cnt;
  logic [7:0]    rx_sh;
  logic [7:0]    tx_sh;
  logic [BW-1:0] byte_idx;
  logic          quiet;
  logic          last_byte;
  logic [7:0]    next_byte;
  logic [BW-1:0] next_idx;

  assign quiet     = ~start_det & ~stop_det;
  assign last_byte = (byte_idx == BW'(BYTES - 1));
  assign ptr_load  = quiet & scl_fall & (state == ST_REG_DEC);
  assign ptr_val   = rx_sh[REG_AW-1:0];
  assign ptr_inc   = quiet & scl_rise & (state == ST_RACK) & last_byte;
  assign next_idx  = last_byte ? '0 : byte_idx + 1'b1;
  assign next_byte = rd_data[DATA_W-1-8*next_idx -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG: if (scl_rise) begin
          rx_sh <= {rx_sh[6:0], sda_s};
          if (cnt == 3'd7) begin
            cnt   <= '0;
            state <= (state == ST_DEV) ? ST_DEV_DEC : ST_REG_DEC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DEV_DEC: if (scl_fall) begin
          if (rx_sh[7:1] == DEV_ID) begin
            sda_oe <= 1'b1;
            state  <= rx_sh[0] ? ST_ACK_R : ST_ACK_W;
          end else begin
            state <= ST_IGNORE;
          end
        end
        ST_ACK_W: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= ST_REG;
        end
        ST_REG_DEC: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK_A;
        end
        ST_ACK_A: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= ST_IGNORE;
        end
        ST_ACK_R: if (scl_fall) begin
          tx_sh    <= rd_data[DATA_W-1 -: 8];
          sda_oe   <= ~rd_data[DATA_W-1];
          byte_idx <= '0;
          cnt      <= '0;
          state    <= ST_TX;
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
            cnt    <= cnt + 1'b1;
          end
        end
        ST_RACK: if (scl_rise) begin
          state <= sda_s ? ST_IGNORE : ST_RACK_GO;
        end
        ST_RACK_GO: if (scl_fall) begin
          tx_sh    <= next_byte;
          sda_oe   <= ~next_byte[7];
          byte_idx <= next_idx;
          cnt      <= '0;
          state    <= ST_TX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h1A,
  parameter int REG_AW = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [REG_AW-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       ptr_load, ptr_inc;
  logic [REG_AW-1:0] ptr_val;
  tgt_state_e state;

  i2c_tgt_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.DEV_ID(DEV_ID), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr_load(ptr_load),
    .ptr_val(ptr_val), .ptr_inc(ptr_inc), .state(state)
  );

  i2c_tgt_ptr #(.REG_AW(REG_AW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .inc(ptr_inc), .ptr(rd_addr)
  );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              ptr_load,
  input logic              ptr_inc,
  input logic [REG_AW-1:0] rd_addr,
  input tgt_state_e        state
);
  // R8: SDA drive moves only while SCL is low
  p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R9: a STOP releases SDA
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R9: a START restarts device address reception
  p_start_dev_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEV));

  // R5: the index only steps by one (with wrap) unless loaded
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != $past(rd_addr)) |->
      ($past(ptr_load) || rd_addr == REG_AW'($past(rd_addr) + 1'b1)));

  // R3 / R5: loading and stepping never coincide
  p_load_xor_inc_r3: assert property (@(posedge clk) disable iff (rst)
    !(ptr_load && ptr_inc));

  // R2 / R7: an ignored transaction leaves SDA released
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .ptr_load(ptr_load),
  .ptr_inc(ptr_inc), .rd_addr(rd_addr), .state(state)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;
  localparam logic [6:0] DEV = 7'h1A;
  localparam int AW = 4;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data;
  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = ~(host_low | sda_oe);

  i2c_regbank_target #(.DEV_ID(DEV), .REG_AW(AW), .DATA_W(16)) u_i2c_regbank_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] regval(input logic [AW-1:0] a);
    return {4'hC, a, ~a, 4'h5};
  endfunction

  // register file model with one clock of latency (R10)
  always @(posedge clk) rd_data <= regval(rd_addr);

  // R8 monitor: SDA drive changes while SCL is high
  always @(posedge clk) begin
    if (!rst && sda_oe != prev_oe && scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    host_low = 1'b0; w(Q); scl = 1'b1; w(Q);
    host_low = 1'b1; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    host_low = 1'b1; w(Q); scl = 1'b1; w(Q);
    host_low = 1'b0; w(2 * Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    host_low = ~b; w(Q); scl = 1'b1; w(Q);
    r = sda_line; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, nack);
  endtask

  task automatic get_byte(input logic host_nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    bit_io(host_nack, r);
  endtask

  task automatic read_regs(input int n, input logic [AW-1:0] first);
    logic [7:0] hi, lo;
    logic [15:0] e;
    for (int i = 0; i < n; i++) begin
      e = regval(first + AW'(i));
      get_byte(1'b0, hi);
      get_byte(i == n - 1, lo);
      chk(hi == e[15:8], "R4 upper byte", {8'h0, hi}, {8'h0, e[15:8]});
      chk(lo == e[7:0], "R5 lower byte / sequence", {8'h0, lo}, {8'h0, e[7:0]});
    end
  endtask

  task automatic rand_read(input logic [7:0] ab, input int n);
    logic nk;
    bus_start;
    put_byte({DEV, 1'b0}, nk);
    chk(nk == 1'b0, "R2 device ack (write)", {15'h0, nk}, 16'h0);
    put_byte(ab, nk);
    chk(nk == 1'b0, "R3 register byte ack", {15'h0, nk}, 16'h0);
    bus_start;
    put_byte({DEV, 1'b1}, nk);
    chk(nk == 1'b0, "R2 device ack (read)", {15'h0, nk}, 16'h0);
    read_regs(n, ab[AW-1:0]);
    bus_stop;
  endtask

  task automatic cont_read(input int n, input logic [AW-1:0] first);
    logic nk;
    bus_start;
    put_byte({DEV, 1'b1}, nk);
    chk(nk == 1'b0, "R6 device ack", {15'h0, nk}, 16'h0);
    read_regs(n, first);
    bus_stop;
  endtask

  // stimulus table: {address byte, register count}
  localparam logic [11:0] VEC [4] = '{
    {8'h03, 4'd2}, {8'h0E, 4'd3}, {8'hF0, 4'd1}, {8'h07, 4'd4}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic nk;
    logic [7:0] d;
    w(5);
    @(negedge clk) rst = 1'b0;
    w(3);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", {15'h0, sda_oe}, 16'h0);
    chk(rd_addr == '0, "R1 index zero", {12'h0, rd_addr}, 16'h0);

    // R3 R4 R5: random reads, including the wrap from 15 to 0 and an address byte with upper bits set
    for (int v = 0; v < 4; v++) rand_read(VEC[v][11:4], int'(VEC[v][3:0]));

    // R6: continued read starts after the last register read (7..10 -> 11)
    cont_read(2, 4'd11);

    // R2: foreign device address is not acknowledged, index untouched
    bus_start;
    put_byte({7'h23, 1'b0}, nk);
    chk(nk == 1'b1, "R2 mismatch nack", {15'h0, nk}, 16'h1);
    put_byte(8'h05, nk);
    chk(nk == 1'b1, "R2 mismatch rest ignored", {15'h0, nk}, 16'h1);
    bus_stop;
    cont_read(1, 4'd13);

    // R3: extra byte after the register number is not acknowledged
    bus_start;
    put_byte({DEV, 1'b0}, nk);
    put_byte(8'h09, nk);
    chk(nk == 1'b0, "R3 register byte ack", {15'h0, nk}, 16'h0);
    put_byte(8'h77, nk);
    chk(nk == 1'b1, "R3 extra byte nack", {15'h0, nk}, 16'h1);
    bus_stop;
    cont_read(1, 4'd9);

    // R7: NACK on an upper byte ends the read; the target stays off the bus
    bus_start;
    put_byte({DEV, 1'b1}, nk);
    get_byte(1'b1, d);
    chk(d == regval(4'd10)[15:8], "R7 upper byte before nack", {8'h0, d}, {8'h0, regval(4'd10)[15:8]});
    get_byte(1'b1, d);
    chk(d == 8'hFF, "R7 released after nack", {8'h0, d}, 16'h00FF);
    bus_stop;
    chk(rd_addr == 4'd10, "R7 incomplete register not counted", {12'h0, rd_addr}, 16'h000A);
    // R9: after STOP the target is idle and SDA free
    chk(sda_oe == 1'b0, "R9 released after stop", {15'h0, sda_oe}, 16'h0);
    cont_read(1, 4'd10);

    // R8: no SDA drive change while SCL was high
    chk(viol == 0, "R8 sda changes only with scl low", 16'(viol), 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule